// File: doc/BRIEF.md
# Per-Slot Compartment Semaphore Bank

This block keeps one hardware mutex for each peripheral slot. A compartment uses the mutex to claim sole ownership of a slot while that slot runs in semaphore mode. Semaphore mode is active only when both the slot's filtering enable and its semaphore enable are high. Each write carries the writing compartment's identifier (CID), the target slot and a take bit. The same take bit acquires the mutex when it is free and releases it when the writer already holds it. Hardware records the owner, so software can read the status back and confirm that its take was accepted.

Only compartments whose bit is set in a slot's whitelist can acquire that slot. Every slot's lock flag and owner CID are driven out continuously to the neighbouring access filter. A read port returns a status word for one selected slot. The bus decode and the access decision made from these outputs belong to other blocks.

Top module: `sem_bank`

## Requirements
- R1: After reset every slot is free (locked flag 0) and its owner CID reads 0.
- R2: A write with take bit 1 to a free slot in semaphore mode, from a CID whose whitelist bit (bit index = CID) is 1, locks the slot with owner = that CID from the next clock edge.
- R3: A take from a CID whose whitelist bit is 0 leaves the slot free and its owner at 0.
- R4: While a slot is held, a write with take bit 1 from any other CID leaves the lock and the owner unchanged. This covers a take attempt and a release attempt by a non-owner.
- R5: A write with take bit 1 from the current owner frees the slot and returns its owner to 0 from the next clock edge.
- R6: A write with take bit 0 changes nothing.
- R7: When a slot's semaphore enable or filtering enable is low, the slot is forced free with owner 0 from the next edge. Take writes to that slot then have no effect.
- R8: rd_data shows the slot chosen by rd_slot with no clock delay. Bit 0 is the locked flag, bits 6:4 are the owner CID, and all other bits are 0.
- R9: A write changes only the slot named by wr_slot.
- R10: Once a release has taken effect, a take by a different whitelisted CID on the very next clock is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_slot | input | SLOT_W | Slot addressed by the write |
| wr_cid | input | 3 | CID of the writer |
| wr_take | input | 1 | Take/release bit of the write |
| cfg_sem_en | input | NUM_SLOTS | Semaphore enable for each slot |
| cfg_filt_en | input | NUM_SLOTS | Filtering enable for each slot |
| cfg_whitelist | input | NUM_SLOTS*8 | CID whitelist for each slot, 8 bits per slot |
| rd_slot | input | SLOT_W | Slot selected for the status read |
| rd_data | output | 32 | Status word of the selected slot |
| owner_cid | output | NUM_SLOTS*3 | Owner CID of each slot |
| locked | output | NUM_SLOTS | Locked flag of each slot |

## Verification
The assertions assume that wr_slot is in range whenever wr_en is high. They also assume that the configuration inputs are stable between clock edges. The stimulus drives every input on the falling edge and addresses only existing slots. Each write lasts one cycle. The bench sweeps every CID against every slot under a distinct whitelist pattern. It then runs contention, enable-drop and back-to-back handover sequences, and compares all slots against its own model after every operation.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int unsigned CID_W = 3;
  localparam int unsigned WL_W  = 1 << CID_W;
  typedef logic [CID_W-1:0] cid_t;
  typedef logic [WL_W-1:0]  wl_t;

  function automatic logic wl_allows(input wl_t wl, input cid_t cid);
    return wl[cid];
  endfunction

  function automatic logic [31:0] pack_status(input logic lk, input cid_t own);
    logic [31:0] w;
    w = '0;
    w[0] = lk;
    w[4 +: CID_W] = own;
    return w;
  endfunction
endpackage

// File: rtl/sem_wr_decode.sv
module sem_wr_decode #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned SLOT_W = 3
) (
  input  logic                 wr_en,
  input  logic [SLOT_W-1:0]    wr_slot,
  output logic [NUM_SLOTS-1:0] hit
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
    assign hit[s] = wr_en && (wr_slot == SLOT_W'(s));
  end
endmodule

// File: rtl/sem_slot.sv
module sem_slot
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_on,
  input  wl_t  wl,
  input  logic wr_hit,
  input  logic wr_take,
  input  cid_t wr_cid,
  output logic locked,
  output cid_t owner
);
  logic locked_q;
  cid_t owner_q;
  logic take_grant;
  logic release_hit;

  assign take_grant  = wr_hit && wr_take && mode_on && !locked_q && wl_allows(wl, wr_cid);
  assign release_hit = wr_hit && wr_take && mode_on && locked_q && (wr_cid == owner_q);

  always_ff @(posedge clk) begin
    if (!rst_n || !mode_on || release_hit) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
    end else if (take_grant) begin
      locked_q <= 1'b1;
      owner_q  <= wr_cid;
    end
  end

  assign locked = locked_q;
  assign owner  = owner_q;

  p_take_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_take && mode_on && !locked_q && wl[wr_cid])
    |=> (locked_q && owner_q == $past(wr_cid)));

  p_not_listed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && mode_on && !locked_q && !wl[wr_cid]) |=> !locked_q);

  p_foreign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && locked_q && wr_hit && wr_cid != owner_q)
    |=> (locked_q && $stable(owner_q)));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && locked_q && wr_hit && wr_take && wr_cid == owner_q)
    |=> (!locked_q && owner_q == '0));

  p_no_take_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && wr_hit && !wr_take) |=> ($stable(locked_q) && $stable(owner_q)));

  p_forced_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_on |=> (!locked_q && owner_q == '0));

  p_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && !wr_hit) |=> ($stable(locked_q) && $stable(owner_q)));

  p_free_owner_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |-> owner_q == '0);
endmodule

// File: rtl/sem_rd_mux.sv
module sem_rd_mux
  import sem_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned SLOT_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SLOT_W-1:0]          rd_slot,
  input  logic [NUM_SLOTS-1:0]       locked,
  input  logic [NUM_SLOTS*CID_W-1:0] owner_cid,
  output logic [31:0]                rd_data
);
  always_comb begin
    rd_data = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (rd_slot == SLOT_W'(s)) rd_data = pack_status(locked[s], owner_cid[s*CID_W +: CID_W]);
    end
  end

  p_rd_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31:7] == '0) && (rd_data[3:1] == '0));
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [SLOT_W-1:0]          wr_slot,
  input  logic [CID_W-1:0]           wr_cid,
  input  logic                       wr_take,
  input  logic [NUM_SLOTS-1:0]       cfg_sem_en,
  input  logic [NUM_SLOTS-1:0]       cfg_filt_en,
  input  logic [NUM_SLOTS*WL_W-1:0]  cfg_whitelist,
  input  logic [SLOT_W-1:0]          rd_slot,
  output logic [31:0]                rd_data,
  output logic [NUM_SLOTS*CID_W-1:0] owner_cid,
  output logic [NUM_SLOTS-1:0]       locked
);
  logic [NUM_SLOTS-1:0] wr_hit;

  sem_wr_decode #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_dec (
    .wr_en(wr_en), .wr_slot(wr_slot), .hit(wr_hit)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic mode_on;
    cid_t own;
    assign mode_on = cfg_sem_en[s] && cfg_filt_en[s];
    sem_slot u_slot (
      .clk(clk), .rst_n(rst_n), .mode_on(mode_on),
      .wl(cfg_whitelist[s*WL_W +: WL_W]),
      .wr_hit(wr_hit[s]), .wr_take(wr_take), .wr_cid(wr_cid),
      .locked(locked[s]), .owner(own)
    );
    assign owner_cid[s*CID_W +: CID_W] = own;
  end

  sem_rd_mux #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_slot(rd_slot), .locked(locked),
    .owner_cid(owner_cid), .rd_data(rd_data)
  );

  p_one_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
endmodule

// File: tb/sim_sem_bank.sv
`timescale 1ns/100ps
module sim_sem_bank;
  localparam int N = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [SW-1:0] wr_slot = '0;
  logic [2:0] wr_cid = '0;
  logic wr_take = 1'b0;
  logic [N-1:0] cfg_sem_en = '1;
  logic [N-1:0] cfg_filt_en = '1;
  logic [N*8-1:0] cfg_whitelist = '0;
  logic [SW-1:0] rd_slot = '0;
  logic [31:0] rd_data;
  logic [N*3-1:0] owner_cid;
  logic [N-1:0] locked;

  int n_checks = 0;
  int n_fail = 0;
  bit m_lk [N];
  int m_own [N];

  always #2.5 clk = ~clk;

  sem_bank #(.NUM_SLOTS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot), .wr_cid(wr_cid),
    .wr_take(wr_take), .cfg_sem_en(cfg_sem_en), .cfg_filt_en(cfg_filt_en),
    .cfg_whitelist(cfg_whitelist), .rd_slot(rd_slot), .rd_data(rd_data),
    .owner_cid(owner_cid), .locked(locked)
  );

  function automatic logic [7:0] wl_of(int s);
    return 8'hA5 ^ 8'((s * 37) & 8'hFF);
  endfunction

  task automatic check_all(string req);
    for (int s = 0; s < N; s++) begin
      logic [31:0] exp;
      rd_slot = SW'(s);
      #0.5;
      exp = (32'(m_own[s]) << 4) | 32'(m_lk[s]);
      n_checks++;
      if (rd_data !== exp || locked[s] !== m_lk[s] || owner_cid[s*3 +: 3] !== 3'(m_own[s])) begin
        n_fail++;
        $display("FAIL %s slot %0d: rd_data=%h locked=%b owner=%0d expected rd_data=%h",
                 req, s, rd_data, locked[s], owner_cid[s*3 +: 3], exp);
      end
    end
  endtask

  task automatic do_write(int s, int cid, bit take);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = SW'(s); wr_cid = 3'(cid); wr_take = take;
    @(negedge clk);
    wr_en = 1'b0; wr_take = 1'b0;
    if (take && cfg_sem_en[s] && cfg_filt_en[s]) begin
      if (!m_lk[s]) begin
        if (wl_of(s)[cid]) begin m_lk[s] = 1; m_own[s] = cid; end
      end else if (m_own[s] == cid) begin
        m_lk[s] = 0; m_own[s] = 0;
      end
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    for (int s = 0; s < N; s++) begin
      cfg_whitelist[s*8 +: 8] = wl_of(s);
      m_lk[s] = 0; m_own[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1/R8 reset");

    // R2 R3 R5: every CID against every slot
    for (int s = 0; s < N; s++) begin
      for (int c = 0; c < 8; c++) begin
        do_write(s, c, 1'b1);
        check_all(wl_of(s)[c] ? "R2 take" : "R3 not whitelisted");
        if (m_lk[s]) begin
          do_write(s, c, 1'b1);
          check_all("R5 release");
        end
      end
    end

    // R4 contention on slot 2, R9 others untouched
    begin
      int a;
      a = 0;
      for (int c = 7; c >= 0; c--) if (wl_of(2)[c]) a = c;
      do_write(2, a, 1'b1);
      check_all("R2 claim");
      for (int c = 0; c < 8; c++) begin
        if (c != a) begin
          do_write(2, c, 1'b1);
          check_all("R4 foreign write");
        end
      end
      do_write(5, a, 1'b1);
      check_all("R9 other slot");
      do_write(2, a, 1'b0);
      check_all("R6 take bit clear");
      // R10 handover back to back
      begin
        int b;
        b = a;
        for (int c = 0; c < 8; c++) if (c != a && wl_of(2)[c]) b = c;
        @(negedge clk);
        wr_en = 1; wr_slot = 2; wr_cid = 3'(a); wr_take = 1;
        @(negedge clk);
        wr_cid = 3'(b);
        @(negedge clk);
        wr_en = 0; wr_take = 0;
        m_lk[2] = (b != a); m_own[2] = (b != a) ? b : 0;
        check_all("R10 handover");
      end
    end

    // R7 enable drop forces free, takes ignored
    do_write(5, 0, 1'b1);
    do_write(6, 0, 1'b1);
    for (int c = 0; c < 8; c++) if (!m_lk[6] && wl_of(6)[c]) do_write(6, c, 1'b1);
    @(negedge clk);
    cfg_sem_en[2] = 0; cfg_filt_en[6] = 0;
    @(negedge clk);
    m_lk[2] = 0; m_own[2] = 0; m_lk[6] = 0; m_own[6] = 0;
    check_all("R7 forced free");
    for (int c = 0; c < 8; c++) begin
      do_write(2, c, 1'b1);
      do_write(6, c, 1'b1);
    end
    check_all("R7 takes ignored");
    @(negedge clk);
    cfg_sem_en[2] = 1; cfg_filt_en[6] = 1;
    @(negedge clk);
    check_all("R7 re-enabled still free");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule